// File: doc/BRIEF.md
# Halfword and Signed-Byte Transfer Address Unit

This unit carries out a single halfword or signed-byte load/store instruction word. It accepts the instruction along with the current base register value and the store source value. From the word it builds an 8-bit immediate offset and works out the transfer address in either pre-indexed or post-indexed form, with the offset added or subtracted. It then makes one access on a simple synchronous memory port.

Load data is taken from the proper byte lanes of the returned 32-bit word. It is then sign-extended or zero-filled according to the transfer type. On completion the unit reports, in a single pulse, the destination register value and index and the updated base value and index, each with its own write enable. Instruction words that no transfer can legally encode are flagged as errors and cause no side effect.

The unit takes one instruction at a time. A caller raises `start_i` while `busy_o` is low and waits for `done_o`.

Top module: `hwxfer_unit`

## Requirements
- R1: The immediate offset is an unsigned 8-bit value whose upper nibble is instruction bits 11:8 and whose lower nibble is instruction bits 3:0.
- R2: Instruction bit 23 set adds the offset to the base, and clear subtracts it. The sum wraps modulo 2^32.
- R3: With instruction bit 24 set, the transfer address is the modified base. With bit 24 clear, the transfer address is the unmodified base.
- R4: `wb_we_o` is raised with `done_o` when bit 24 is set and bit 21 is set, and always when bit 24 is clear. `wb_data_o` is the modified base and `wb_idx_o` is instruction bits 19:16.
- R5: An instruction with bits 6:5 equal to 00, or with bit 24 clear and bit 21 set, finishes with `err_o` high. It makes no memory request and raises neither `rd_we_o` nor `wb_we_o`.
- R6: When bit 20 is 1 (load) and bits 6:5 are 01, a 16-bit lane is selected: bits 15:0 when address bit 1 is 0, and bits 31:16 otherwise. That lane is zero-filled to 32 bits, and `mem_be_o` is 0011 or 1100 to match.
- R7: A load with bits 6:5 equal to 10 selects the byte lane given by address bits 1:0, sign-extends its bit 7, and drives a one-hot `mem_be_o` for that lane.
- R8: A load with bits 6:5 equal to 11 selects the 16-bit lane as in R6 and sign-extends its bit 15.
- R9: When bit 20 is 0 (store), the unit raises `mem_we_o` and drives the low 16 bits of `src_i` on both halves of `mem_wdata_o`. `mem_be_o` is 0011 or 1100 by address bit 1, and `rd_we_o` stays low.
- R10: `mem_req_o` and `mem_addr_o` stay steady until `mem_ack_i` is sampled high. `done_o` then rises for exactly one cycle.
- R11: `rd_idx_o` reports instruction bits 15:12. `rd_we_o` rises with `done_o` only for legal loads.
- R12: After reset, `busy_o`, `mem_req_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Accept the instruction (only when not busy) |
| instr_i | input | 32 | Instruction word |
| base_i | input | 32 | Base register value |
| src_i | input | 32 | Store source register value |
| busy_o | output | 1 | An instruction is in progress |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 32 | Transfer byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_be_o | output | 4 | Byte lane enables |
| mem_ack_i | input | 1 | Memory accepts / completes the request |
| mem_rdata_i | input | 32 | Read data, valid with the acknowledge |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Illegal encoding, valid with done |
| rd_we_o | output | 1 | Destination write enable |
| rd_idx_o | output | 4 | Destination register index |
| rd_data_o | output | 32 | Extended load value |
| wb_we_o | output | 1 | Base write-back enable |
| wb_idx_o | output | 4 | Base register index |
| wb_data_o | output | 32 | Modified base value |

## Verification
A wrong latched field or a wrong decode shows up as a wrong `mem_addr_o` or `mem_be_o` at the very first negative edge of the request. The memory model checks these before it acknowledges. A lane-select or extension fault stays hidden until the completion pulse, where `rd_data_o` is compared against a value the bench rebuilds from its own memory function. A control-state fault appears either as a request on an illegal word, or as a completion pulse that is missing, lasts more than one cycle, or carries the wrong enables. The watchdog catches a request that never ends.

// File: rtl/hwx_pkg.sv
// Shared widths and types for the halfword/signed transfer unit.
// Assumes a 32-bit register file and a 32-bit, four-lane memory bus.
package hwx_pkg;
    localparam int REG_W   = 32;
    localparam int OFF_W   = 8;
    localparam int NIB_W   = OFF_W / 2;
    localparam int IDX_W   = 4;
    localparam int LANES   = REG_W / 8;
    localparam int HALF_W  = REG_W / 2;

    typedef enum logic [1:0] {
        XK_NONE  = 2'b00,
        XK_UHALF = 2'b01,
        XK_SBYTE = 2'b10,
        XK_SHALF = 2'b11
    } xfer_kind_e;

    typedef struct packed {
        logic             pre;
        logic             up;
        logic             wback;
        logic             load;
        logic [IDX_W-1:0] base_idx;
        logic [IDX_W-1:0] data_idx;
        logic [OFF_W-1:0] offset;
        xfer_kind_e       kind;
        logic             illegal;
        logic             base_upd;
    } hwx_ctl_t;
endpackage

// File: rtl/hwx_decode.sv
// Splits an instruction word into transfer controls.
// Assumes the caller has already chosen the immediate-offset halfword form;
// the fixed opcode bits are not checked here.
module hwx_decode
    import hwx_pkg::*;
(
    input  logic [REG_W-1:0] instr_i,
    output hwx_ctl_t         ctl_o
);
    logic ignored_unused;
    assign ignored_unused = ^{instr_i[31:25], instr_i[22], instr_i[7], instr_i[4]};

    // Field extraction and legality of the pre/post + write-back pairing.
    always_comb begin
        ctl_o          = '0;
        ctl_o.pre      = instr_i[24];
        ctl_o.up       = instr_i[23];
        ctl_o.wback    = instr_i[21];
        ctl_o.load     = instr_i[20];
        ctl_o.base_idx = instr_i[19:16];
        ctl_o.data_idx = instr_i[15:12];
        ctl_o.offset   = {instr_i[11:8], instr_i[3:0]};
        ctl_o.kind     = xfer_kind_e'(instr_i[6:5]);
        ctl_o.illegal  = (ctl_o.kind == XK_NONE) || (!ctl_o.pre && ctl_o.wback);
        ctl_o.base_upd = !ctl_o.pre || ctl_o.wback;
    end
endmodule

// File: rtl/hwx_addr.sv
// Forms the modified base and the transfer address.
// Assumes an unsigned offset; arithmetic wraps at the register width.
module hwx_addr #(
    parameter int AW = 32,
    parameter int OW = 8
) (
    input  logic [AW-1:0] base_i,
    input  logic [OW-1:0] offset_i,
    input  logic          up_i,
    input  logic          pre_i,
    output logic [AW-1:0] xfer_addr_o,
    output logic [AW-1:0] new_base_o
);
    localparam int PAD_W = AW - OW;

    logic [AW-1:0] off_ext;

    // Zero-extend the offset and apply it in the selected direction.
    always_comb begin
        off_ext     = {{PAD_W{1'b0}}, offset_i};
        new_base_o  = up_i ? (base_i + off_ext) : (base_i - off_ext);
        xfer_addr_o = pre_i ? new_base_o : base_i;
    end

    // Check the modified base by inverting the operation (R2).
    always_comb begin
        if (up_i)
            assert_wrap_up_R2: assert (new_base_o - base_i == off_ext);
        else
            assert_wrap_down_R2: assert (base_i - new_base_o == off_ext);
    end
endmodule

// File: rtl/hwx_extend.sv
// Picks the loaded lane from a 32-bit read word and extends it.
// Assumes halfword lanes are chosen by address bit 1 and byte lanes by bits 1:0.
module hwx_extend
    import hwx_pkg::*;
(
    input  xfer_kind_e       kind_i,
    input  logic [1:0]       lane_i,
    input  logic [REG_W-1:0] rdata_i,
    output logic [REG_W-1:0] data_o
);
    logic [HALF_W-1:0] half_v;
    logic [7:0]        byte_v;

    // Lane selection followed by sign or zero extension.
    always_comb begin
        half_v = lane_i[1] ? rdata_i[REG_W-1:HALF_W] : rdata_i[HALF_W-1:0];
        byte_v = rdata_i[8*lane_i +: 8];
        unique case (kind_i)
            XK_SBYTE: data_o = {{(REG_W-8){byte_v[7]}}, byte_v};
            XK_SHALF: data_o = {{HALF_W{half_v[HALF_W-1]}}, half_v};
            XK_UHALF: data_o = {{HALF_W{1'b0}}, half_v};
            default:  data_o = '0;
        endcase
    end

    // Upper bits must follow the extension rule of the transfer type (R6, R7).
    always_comb begin
        if (kind_i == XK_SBYTE)
            assert_sbyte_fill_R7: assert (data_o[REG_W-1:8] == {(REG_W-8){data_o[7]}});
        if (kind_i == XK_UHALF)
            assert_uhalf_zero_R6: assert (data_o[REG_W-1:HALF_W] == '0);
    end
endmodule

// File: rtl/hwxfer_unit.sv
// Executes one halfword / signed-byte load or store against a synchronous
// memory port and reports destination and base write-back values.
// Assumes start_i is only raised while busy_o is low and that the memory
// holds mem_rdata_i valid in the cycle mem_ack_i is high.
module hwxfer_unit
    import hwx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [REG_W-1:0]   instr_i,
    input  logic [REG_W-1:0]   base_i,
    input  logic [REG_W-1:0]   src_i,
    output logic               busy_o,
    output logic               mem_req_o,
    output logic               mem_we_o,
    output logic [REG_W-1:0]   mem_addr_o,
    output logic [REG_W-1:0]   mem_wdata_o,
    output logic [LANES-1:0]   mem_be_o,
    input  logic               mem_ack_i,
    input  logic [REG_W-1:0]   mem_rdata_i,
    output logic               done_o,
    output logic               err_o,
    output logic               rd_we_o,
    output logic [IDX_W-1:0]   rd_idx_o,
    output logic [REG_W-1:0]   rd_data_o,
    output logic               wb_we_o,
    output logic [IDX_W-1:0]   wb_idx_o,
    output logic [REG_W-1:0]   wb_data_o
);
    typedef enum logic [1:0] {ST_IDLE, ST_ACCESS, ST_FINISH} st_e;

    st_e               state;
    logic [REG_W-1:0]  instr_q;
    logic [REG_W-1:0]  base_q;
    logic [HALF_W-1:0] src_q;
    logic [REG_W-1:0]  rdata_q;
    hwx_ctl_t          ctl;
    logic [REG_W-1:0]  new_base;
    logic [REG_W-1:0]  xfer_addr;
    logic [REG_W-1:0]  ext_data;

    hwx_decode u_decode (
        .instr_i (instr_q),
        .ctl_o   (ctl)
    );

    hwx_addr #(.AW(REG_W), .OW(OFF_W)) u_addr (
        .base_i      (base_q),
        .offset_i    (ctl.offset),
        .up_i        (ctl.up),
        .pre_i       (ctl.pre),
        .xfer_addr_o (xfer_addr),
        .new_base_o  (new_base)
    );

    hwx_extend u_extend (
        .kind_i  (ctl.kind),
        .lane_i  (xfer_addr[1:0]),
        .rdata_i (rdata_q),
        .data_o  (ext_data)
    );

    // Sequencer: latch the operands, wait for the acknowledge, pulse done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            instr_q <= '0;
            base_q  <= '0;
            src_q   <= '0;
            rdata_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        instr_q <= instr_i;
                        base_q  <= base_i;
                        src_q   <= src_i[HALF_W-1:0];
                        state   <= ST_ACCESS;
                    end
                end
                ST_ACCESS: begin
                    if (ctl.illegal) begin
                        state <= ST_FINISH;
                    end else if (mem_ack_i) begin
                        rdata_q <= mem_rdata_i;
                        state   <= ST_FINISH;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Memory request fields derived from the latched instruction.
    always_comb begin
        mem_req_o   = (state == ST_ACCESS) && !ctl.illegal;
        mem_we_o    = !ctl.load;
        mem_addr_o  = xfer_addr;
        mem_wdata_o = {src_q, src_q};
        if (ctl.load && ctl.kind == XK_SBYTE)
            mem_be_o = LANES'(1) << xfer_addr[1:0];
        else
            mem_be_o = xfer_addr[1] ? 4'b1100 : 4'b0011;
    end

    // Completion reporting, valid only during the done pulse.
    always_comb begin
        busy_o    = (state != ST_IDLE);
        done_o    = (state == ST_FINISH);
        err_o     = done_o && ctl.illegal;
        rd_we_o   = done_o && !ctl.illegal && ctl.load;
        rd_idx_o  = ctl.data_idx;
        rd_data_o = ext_data;
        wb_we_o   = done_o && !ctl.illegal && ctl.base_upd;
        wb_idx_o  = ctl.base_idx;
        wb_data_o = new_base;
    end

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_err_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (!rd_we_o && !wb_we_o && $past(!mem_req_o)));

    assert_post_wb_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o && !instr_q[24]) |-> wb_we_o);

    assert_store_no_rd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !instr_q[20]) |-> !rd_we_o);
endmodule

// File: tb/hwxfer_unit_bench.sv
// Scoreboard bench: the driver queues expected items, a memory responder and
// a completion monitor pop and compare them.
module hwxfer_unit_bench;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] instr_i = '0;
    logic [31:0] base_i = '0;
    logic [31:0] src_i = '0;
    logic        busy_o, mem_req_o, mem_we_o;
    logic [31:0] mem_addr_o, mem_wdata_o;
    logic [3:0]  mem_be_o;
    logic        mem_ack_i = 1'b0;
    logic [31:0] mem_rdata_i = '0;
    logic        done_o, err_o, rd_we_o, wb_we_o;
    logic [3:0]  rd_idx_o, wb_idx_o;
    logic [31:0] rd_data_o, wb_data_o;

    hwxfer_unit u_hwxfer_unit (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .instr_i(instr_i),
        .base_i(base_i), .src_i(src_i), .busy_o(busy_o),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_be_o(mem_be_o), .mem_ack_i(mem_ack_i),
        .mem_rdata_i(mem_rdata_i), .done_o(done_o), .err_o(err_o),
        .rd_we_o(rd_we_o), .rd_idx_o(rd_idx_o), .rd_data_o(rd_data_o),
        .wb_we_o(wb_we_o), .wb_idx_o(wb_idx_o), .wb_data_o(wb_data_o)
    );

    always #(CLK_P/2) clk = ~clk;

    typedef struct {
        logic        err;
        logic        we;
        logic [31:0] addr;
        logic [3:0]  be;
        logic [31:0] wdata;
        logic        rd_we;
        logic [3:0]  rd_idx;
        logic [31:0] rd_data;
        logic        wb_we;
        logic [3:0]  wb_idx;
        logic [31:0] wb_data;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    int   ack_delay = 0;
    bit   reported = 0;

    // Deterministic memory contents, a function of the word address.
    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {a[31:2], 2'b00} * 32'h9E37_79B1 ^ 32'h8000_8080;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!reported) begin
            reported = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        end
        $finish;
    endtask

    // Build the word, predict every outcome, queue it, and run the instruction.
    task automatic run(input bit p, input bit u, input bit w, input bit l,
                       input logic [3:0] rn, input logic [3:0] rd, input logic [7:0] off,
                       input bit s, input bit h, input logic [31:0] base,
                       input logic [31:0] src, input int dly);
        exp_t        e;
        logic [31:0] ins, nb, word;
        logic [15:0] hv;
        logic [7:0]  bv;
        ins = {4'hE, 3'b000, p, u, 1'b1, w, l, rn, rd, off[7:4], 1'b1, s, h, 1'b1, off[3:0]};
        nb  = u ? base + {24'd0, off} : base - {24'd0, off};
        e.err    = ({s, h} == 2'b00) || (!p && w);
        e.we     = !l;
        e.addr   = p ? nb : base;
        e.wdata  = {src[15:0], src[15:0]};
        if (l && {s, h} == 2'b10) e.be = 4'b0001 << e.addr[1:0];
        else e.be = e.addr[1] ? 4'b1100 : 4'b0011;
        word = mem_word(e.addr);
        hv   = e.addr[1] ? word[31:16] : word[15:0];
        bv   = word[8*e.addr[1:0] +: 8];
        case ({s, h})
            2'b01:   e.rd_data = {16'd0, hv};
            2'b10:   e.rd_data = {{24{bv[7]}}, bv};
            default: e.rd_data = {{16{hv[15]}}, hv};
        endcase
        e.rd_we   = l && !e.err;
        e.rd_idx  = rd;
        e.wb_we   = (!p || w) && !e.err;
        e.wb_idx  = rn;
        e.wb_data = nb;
        q.push_back(e);
        ack_delay = dly;
        @(negedge clk);
        start_i = 1'b1; instr_i = ins; base_i = base; src_i = src;
        @(negedge clk);
        start_i = 1'b0;
        while (q.size() != 0) @(posedge clk);
        @(negedge clk);
        chk("R10 done single pulse", {31'd0, done_o}, 32'd0);
    endtask

    // Memory responder: checks the request, holds it for the delay, acknowledges.
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req_o) begin
                if (q.size() == 0 || q[0].err) begin
                    n_chk++; n_fail++;
                    $display("FAIL R5 request on illegal or absent item actual=%h expected=none", mem_addr_o);
                    mem_ack_i = 1'b1;
                    @(negedge clk);
                    mem_ack_i = 1'b0;
                end else begin
                    for (int k = 0; k < ack_delay; k++) begin
                        chk("R10 addr held while waiting", mem_addr_o, q[0].addr);
                        @(negedge clk);
                        chk("R10 request held", {31'd0, mem_req_o}, 32'd1);
                    end
                    chk("R1 R2 R3 transfer address", mem_addr_o, q[0].addr);
                    chk("R9 write enable", {31'd0, mem_we_o}, {31'd0, q[0].we});
                    chk("R6 R7 R9 byte enables", {28'd0, mem_be_o}, {28'd0, q[0].be});
                    if (q[0].we) chk("R9 write data", mem_wdata_o, q[0].wdata);
                    mem_rdata_i = q[0].we ? 32'h0 : mem_word(mem_addr_o);
                    mem_ack_i   = 1'b1;
                    @(negedge clk);
                    mem_ack_i   = 1'b0;
                end
            end
        end
    end

    // Completion monitor: pops the oldest expectation and compares results.
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (done_o) begin
                if (q.size() == 0) begin
                    n_chk++; n_fail++;
                    $display("FAIL R10 done without start actual=1 expected=0");
                end else begin
                    e = q.pop_front();
                    chk("R5 error flag", {31'd0, err_o}, {31'd0, e.err});
                    chk("R11 rd write enable", {31'd0, rd_we_o}, {31'd0, e.rd_we});
                    chk("R4 base write enable", {31'd0, wb_we_o}, {31'd0, e.wb_we});
                    if (e.rd_we) begin
                        chk("R6 R7 R8 load data", rd_data_o, e.rd_data);
                        chk("R11 rd index", {28'd0, rd_idx_o}, {28'd0, e.rd_idx});
                    end
                    if (e.wb_we) begin
                        chk("R4 base value", wb_data_o, e.wb_data);
                        chk("R4 base index", {28'd0, wb_idx_o}, {28'd0, e.wb_idx});
                    end
                end
            end
        end
    end

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        #(CLK_P * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R12 busy after reset", {31'd0, busy_o}, 32'd0);
        chk("R12 request after reset", {31'd0, mem_req_o}, 32'd0);
        chk("R12 done after reset", {31'd0, done_o}, 32'd0);
        rst_n = 1'b1;
        // R1 R3 R6: pre-indexed up, no write-back, unsigned half from upper lane
        run(1, 1, 0, 1, 4'd2, 4'd5, 8'h5A, 0, 1, 32'h0000_1000, 32'h0, 0);
        // R2 R4: pre-indexed down wrapping below zero, write-back on
        run(1, 0, 1, 1, 4'd7, 4'd1, 8'h10, 0, 1, 32'h0000_0004, 32'h0, 1);
        // R2 R3 R4 R8: post-indexed up wrapping, signed half, base always updated
        run(0, 1, 0, 1, 4'd9, 4'd3, 8'hFF, 1, 1, 32'hFFFF_FFF0, 32'h0, 2);
        // R7: signed byte in every lane
        for (int k = 0; k < 4; k++)
            run(1, 1, 0, 1, 4'd4, 4'(k + 8), 8'(k * 5), 1, 0, 32'h0000_2000, 32'h0, k);
        // R8: signed half from lower lane
        run(1, 1, 0, 1, 4'd3, 4'd14, 8'h24, 1, 1, 32'h0001_0000, 32'h0, 0);
        // R9: store to lower half, pre-indexed
        run(1, 1, 0, 0, 4'd6, 4'd2, 8'h04, 0, 1, 32'h0000_3000, 32'hDEAD_BEEF, 1);
        // R9 R4: post-indexed store to upper half, base decremented
        run(0, 0, 0, 0, 4'd11, 4'd12, 8'h22, 1, 1, 32'h0000_3002, 32'h1234_5678, 3);
        // R5: transfer type 00
        run(1, 1, 1, 1, 4'd1, 4'd1, 8'h08, 0, 0, 32'h0000_4000, 32'h0, 0);
        // R5: post-indexed with write-back bit set
        run(0, 1, 1, 1, 4'd1, 4'd2, 8'h08, 0, 1, 32'h0000_4000, 32'h0, 0);
        // R4: post-indexed load, write-back bit clear, long wait
        run(0, 0, 0, 1, 4'd13, 4'd0, 8'h81, 0, 1, 32'h8000_0000, 32'h0, 5);
        summary();
    end
endmodule